// File: doc/BRIEF.md
# Prioritised Request Intake with Run-down

This block is the front of a store-access pipeline. Four request ports compete for it: a high-priority instruction fetch port, two operand ports, and an ordinary prefetch port. Each cycle the block picks one request by fixed priority. It copies that request's address, tag and control bits into a first stage register and answers the winner with an accept pulse in the same cycle. Accepted entries then move through two more stage registers, and the last of these drives the output. The consumer retires the output entry with `outReady` and returns the translation result for it on `outMiss`.

The prefetch port is the busiest requester, and it still has the lowest priority. This is deliberate: a tight predicted loop must not be able to fill the unit and hold back operand requests from older instructions.

A translation miss on a non-prefetch entry puts the block into run-down. While it is in run-down:
- the failing-address register stops loading, so it keeps the address of the failing entry;
- new requests are answered and thrown away, each with a discard flag;
- the `rundown` output tells the operand queue to run down as well.

A request on operand port B that carries the resume bit ends run-down. It is loaded as a normal entry.

Top module: `req_intake`

## Requirements
- R1: One request at most is accepted per cycle. The priority order is fetch (source code 0), then operand A (1), then operand B (2), then prefetch (3). A port is never accepted while a port of higher priority is requesting.
- R2: Outside run-down, the winner is accepted only when stage A is free or is advancing in that cycle. Its fields reach the output in order through stages A, B and C. When the pipeline is empty and `outReady` is high, an entry accepted at one clock edge is at the output after the second edge that follows it. `outSrc` carries the source code of the entry.
- R3: While `outReady` is low and all three stages are full, no request is loaded.
- R4: Outside run-down, `failAddr` takes the address of each entry as it enters stage C. The address is not taken if a triggering miss retires in the same cycle.
- R5: A triggering miss is an entry that retires with `outMiss` high, outside run-down, from a source other than prefetch. It causes `missIrq` to pulse for one cycle after the retiring edge, and `rundown` goes high in that same cycle. A retiring prefetch entry with `outMiss` high pulses `pfMissRpt` instead and does not start run-down.
- R6: While `rundown` is high, `failAddr` does not change.
- R7: In run-down, the winning request is accepted at once, whether or not stage A is occupied, unless it is a resume request. It gets `dropFlag` with its accept pulse and never reaches the output.
- R8: Entries already in the pipeline when run-down starts still retire normally. Misses on them raise neither `missIrq` nor a new failing address.
- R9: In run-down, a winning port-B request with `obResume` high is loaded like a normal request, and `rundown` falls in the next cycle. Outside run-down, `obResume` has no effect.
- R10: After reset there are no accepts and no output entry. `rundown`, `missIrq`, `pfMissRpt` and `failAddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hpReq | input | 1 | High-priority fetch request |
| hpAddr | input | ADDR_W | Fetch address |
| hpTag | input | TAG_W | Fetch tag |
| hpCtrl | input | CTRL_W | Fetch control bits |
| hpAcc | output | 1 | Fetch accept pulse |
| oaReq | input | 1 | Operand port A request |
| oaAddr | input | ADDR_W | Operand A address |
| oaTag | input | TAG_W | Operand A tag |
| oaCtrl | input | CTRL_W | Operand A control bits |
| oaAcc | output | 1 | Operand A accept pulse |
| obReq | input | 1 | Operand port B (operand-issue unit) request |
| obAddr | input | ADDR_W | Operand B address |
| obTag | input | TAG_W | Operand B tag |
| obCtrl | input | CTRL_W | Operand B control bits |
| obResume | input | 1 | Marks the request as the run-down resume request |
| obAcc | output | 1 | Operand B accept pulse |
| pfReq | input | 1 | Ordinary prefetch request |
| pfAddr | input | ADDR_W | Prefetch address |
| pfTag | input | TAG_W | Prefetch tag |
| pfCtrl | input | CTRL_W | Prefetch control bits |
| pfAcc | output | 1 | Prefetch accept pulse |
| dropFlag | output | 1 | The accept in this cycle is a discard |
| outValid | output | 1 | Stage C holds an entry |
| outAddr | output | ADDR_W | Stage C address |
| outTag | output | TAG_W | Stage C tag |
| outCtrl | output | CTRL_W | Stage C control bits |
| outSrc | output | 2 | Stage C source code |
| outReady | input | 1 | Consumer takes the stage C entry |
| outMiss | input | 1 | Translation miss for the retiring entry |
| missIrq | output | 1 | Miss interrupt pulse |
| pfMissRpt | output | 1 | Prefetch miss report pulse |
| rundown | output | 1 | Run-down mode |
| failAddr | output | ADDR_W | Failing-address register |

## Verification
A wrong stage-valid bit shows up as a lost, duplicated or reordered entry at the output within three cycles. A stuck-full stage shows up as an accept withheld in the same cycle. A wrong run-down flag shows up in the very cycle it goes wrong: a request is discarded when it should have been loaded, or loaded when it should have been discarded. It also shows as `failAddr` moving while it should be frozen. The bench keeps a behavioural model in step with the design and compares every output on every cycle, so any divergence is caught in the cycle it first appears.

// File: rtl/intake_pkg.sv
package intake_pkg;
  localparam int NP = 4;

  typedef enum logic [1:0] {
    SRC_HP = 2'd0,
    SRC_OA = 2'd1,
    SRC_OB = 2'd2,
    SRC_PF = 2'd3
  } srcT;

  typedef struct packed {
    logic loadA;
    logic advA;
    logic advB;
    logic loadNa;
    srcT  winSrc;
  } stageStrobesT;
endpackage

// File: rtl/intake_ctrl.sv
module intake_ctrl
  import intake_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [NP-1:0] req,
  input  logic          obResume,
  input  logic          outReady,
  input  logic          outMiss,
  input  srcT           cSrc,
  output logic [NP-1:0] acc,
  output logic          dropFlag,
  output logic          outValid,
  output logic          missIrq,
  output logic          pfMissRpt,
  output logic          rundown,
  output stageStrobesT  str
);
  logic aValid, bValid, cValid;
  logic retire, advA, advB, aFree;
  logic anyReq, isResume, discard, take, trig, pfTrig;
  srcT  winIdx;

  always_comb begin
    winIdx = SRC_PF;
    anyReq = |req;
    for (int i = NP - 1; i >= 0; i--) begin
      if (req[i]) winIdx = srcT'(i);
    end
  end

  always_comb begin
    retire   = cValid && outReady;
    advB     = bValid && (!cValid || retire);
    advA     = aValid && (!bValid || advB);
    aFree    = !aValid || advA;
    isResume = anyReq && (winIdx == SRC_OB) && obResume;
    discard  = anyReq && rundown && !isResume;
    take     = anyReq && !discard && aFree;
    trig     = retire && outMiss && !rundown && (cSrc != SRC_PF);
    pfTrig   = retire && outMiss && (cSrc == SRC_PF);
  end

  generate
    for (genvar g = 0; g < NP; g++) begin : gAcc
      assign acc[g] = (discard || take) && (winIdx == srcT'(g));
    end
  endgenerate

  assign dropFlag   = discard;
  assign outValid   = cValid;
  assign str.loadA  = take;
  assign str.advA   = advA;
  assign str.advB   = advB;
  assign str.loadNa = advB && !rundown && !trig;
  assign str.winSrc = winIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aValid    <= 1'b0;
      bValid    <= 1'b0;
      cValid    <= 1'b0;
      rundown   <= 1'b0;
      missIrq   <= 1'b0;
      pfMissRpt <= 1'b0;
    end else begin
      aValid    <= take || (aValid && !advA);
      bValid    <= advA || (bValid && !advB);
      cValid    <= advB || (cValid && !retire);
      missIrq   <= trig;
      pfMissRpt <= pfTrig;
      if (trig) rundown <= 1'b1;
      else if (take && isResume) rundown <= 1'b0;
    end
  end

  // R1
  prio_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc[3] |-> !req[0] && !req[1] && !req[2]) and
    (acc[2] |-> !req[0] && !req[1]) and (acc[1] |-> !req[0]));

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aValid && bValid && cValid && !outReady) |-> (acc == '0 || dropFlag));

  // R5
  miss_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outMiss && !rundown && cSrc != SRC_PF)
      |=> (rundown && missIrq));

  // R7
  drop_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropFlag |=> (aValid == $past(aValid && !advA)));

  // R9
  resume_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rundown && obResume && acc[2] && !dropFlag) |=> !rundown);
endmodule

// File: rtl/intake_path.sv
module intake_path
  import intake_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int TAG_W  = 4,
  parameter int CTRL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobesT      str,
  input  logic              rundownIn,
  input  logic [ADDR_W-1:0] reqAddr [NP],
  input  logic [TAG_W-1:0]  reqTag  [NP],
  input  logic [CTRL_W-1:0] reqCtrl [NP],
  output logic [ADDR_W-1:0] outAddr,
  output logic [TAG_W-1:0]  outTag,
  output logic [CTRL_W-1:0] outCtrl,
  output srcT               cSrc,
  output logic [ADDR_W-1:0] failAddr
);
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag;
    logic [CTRL_W-1:0] ctrl;
    srcT               src;
  } entryT;

  entryT stA, stB, stC, newEntry;

  always_comb begin
    newEntry.addr = reqAddr[str.winSrc];
    newEntry.tag  = reqTag[str.winSrc];
    newEntry.ctrl = reqCtrl[str.winSrc];
    newEntry.src  = str.winSrc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stA      <= '0;
      stB      <= '0;
      stC      <= '0;
      failAddr <= '0;
    end else begin
      if (str.loadA)  stA      <= newEntry;
      if (str.advA)   stB      <= stA;
      if (str.advB)   stC      <= stB;
      if (str.loadNa) failAddr <= stB.addr;
    end
  end

  assign outAddr = stC.addr;
  assign outTag  = stC.tag;
  assign outCtrl = stC.ctrl;
  assign cSrc    = stC.src;

  // R6
  fail_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    rundownIn |=> $stable(failAddr));

  // R4
  fail_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.loadNa |=> (failAddr == stC.addr));
endmodule

// File: rtl/req_intake.sv
module req_intake
  import intake_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int TAG_W  = 4,
  parameter int CTRL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hpReq,
  input  logic [ADDR_W-1:0] hpAddr,
  input  logic [TAG_W-1:0]  hpTag,
  input  logic [CTRL_W-1:0] hpCtrl,
  output logic              hpAcc,
  input  logic              oaReq,
  input  logic [ADDR_W-1:0] oaAddr,
  input  logic [TAG_W-1:0]  oaTag,
  input  logic [CTRL_W-1:0] oaCtrl,
  output logic              oaAcc,
  input  logic              obReq,
  input  logic [ADDR_W-1:0] obAddr,
  input  logic [TAG_W-1:0]  obTag,
  input  logic [CTRL_W-1:0] obCtrl,
  input  logic              obResume,
  output logic              obAcc,
  input  logic              pfReq,
  input  logic [ADDR_W-1:0] pfAddr,
  input  logic [TAG_W-1:0]  pfTag,
  input  logic [CTRL_W-1:0] pfCtrl,
  output logic              pfAcc,
  output logic              dropFlag,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [TAG_W-1:0]  outTag,
  output logic [CTRL_W-1:0] outCtrl,
  output logic [1:0]        outSrc,
  input  logic              outReady,
  input  logic              outMiss,
  output logic              missIrq,
  output logic              pfMissRpt,
  output logic              rundown,
  output logic [ADDR_W-1:0] failAddr
);
  logic [NP-1:0]     req, acc;
  logic [ADDR_W-1:0] reqAddr [NP];
  logic [TAG_W-1:0]  reqTag  [NP];
  logic [CTRL_W-1:0] reqCtrl [NP];
  stageStrobesT      str;
  srcT               cSrc;

  assign req = {pfReq, obReq, oaReq, hpReq};
  assign reqAddr[0] = hpAddr;  assign reqTag[0] = hpTag;  assign reqCtrl[0] = hpCtrl;
  assign reqAddr[1] = oaAddr;  assign reqTag[1] = oaTag;  assign reqCtrl[1] = oaCtrl;
  assign reqAddr[2] = obAddr;  assign reqTag[2] = obTag;  assign reqCtrl[2] = obCtrl;
  assign reqAddr[3] = pfAddr;  assign reqTag[3] = pfTag;  assign reqCtrl[3] = pfCtrl;
  assign {pfAcc, obAcc, oaAcc, hpAcc} = acc;
  assign outSrc = cSrc;

  intake_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .req(req), .obResume(obResume),
    .outReady(outReady), .outMiss(outMiss), .cSrc(cSrc),
    .acc(acc), .dropFlag(dropFlag), .outValid(outValid),
    .missIrq(missIrq), .pfMissRpt(pfMissRpt), .rundown(rundown), .str(str)
  );

  intake_path #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .CTRL_W(CTRL_W)) uPath (
    .clk(clk), .rstN(rstN), .str(str), .rundownIn(rundown),
    .reqAddr(reqAddr), .reqTag(reqTag), .reqCtrl(reqCtrl),
    .outAddr(outAddr), .outTag(outTag), .outCtrl(outCtrl),
    .cSrc(cSrc), .failAddr(failAddr)
  );
endmodule

// File: tb/tb_req_intake.sv
module tb_req_intake;
  localparam int AW = 24, TW = 4, CW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  always #10 clk = ~clk;

  logic          reqV [4];
  logic [AW-1:0] rAddr [4];
  logic [TW-1:0] rTag [4];
  logic [CW-1:0] rCtrl [4];
  logic obRes = 1'b0, outReady = 1'b0, outMiss = 1'b0;
  logic hpAcc, oaAcc, obAcc, pfAcc, dropFlag, outValid, missIrq, pfMissRpt, rundown;
  logic [AW-1:0] outAddr, failAddr;
  logic [TW-1:0] outTag;
  logic [CW-1:0] outCtrl;
  logic [1:0]    outSrc;

  req_intake #(.ADDR_W(AW), .TAG_W(TW), .CTRL_W(CW)) dut (
    .clk(clk), .rstN(rstN),
    .hpReq(reqV[0]), .hpAddr(rAddr[0]), .hpTag(rTag[0]), .hpCtrl(rCtrl[0]), .hpAcc(hpAcc),
    .oaReq(reqV[1]), .oaAddr(rAddr[1]), .oaTag(rTag[1]), .oaCtrl(rCtrl[1]), .oaAcc(oaAcc),
    .obReq(reqV[2]), .obAddr(rAddr[2]), .obTag(rTag[2]), .obCtrl(rCtrl[2]),
    .obResume(obRes), .obAcc(obAcc),
    .pfReq(reqV[3]), .pfAddr(rAddr[3]), .pfTag(rTag[3]), .pfCtrl(rCtrl[3]), .pfAcc(pfAcc),
    .dropFlag(dropFlag), .outValid(outValid), .outAddr(outAddr), .outTag(outTag),
    .outCtrl(outCtrl), .outSrc(outSrc), .outReady(outReady), .outMiss(outMiss),
    .missIrq(missIrq), .pfMissRpt(pfMissRpt), .rundown(rundown), .failAddr(failAddr)
  );

  int nChecks = 0, nFail = 0, cycles = 0;
  int reqPct = 50, readyPct = 100, missPct = 0, resPct = 20;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", rq, what, act, exp, cycles);
    end
  endtask

  // reference model: in-flight entries as a list of slots, mode flag, registers
  int  mV [3];
  int  mA [3], mT [3], mC [3], mS [3];
  int  mRd, mFa, mIrq, mPf;
  int  nV [3];
  int  nA [3], nT [3], nC [3], nS [3];
  int  nRd, nFa, nIrq, nPf;
  bit  lastAcc [4];

  initial begin
    for (int i = 0; i < 3; i++) begin mV[i] = 0; mA[i] = 0; mT[i] = 0; mC[i] = 0; mS[i] = 0; end
    mRd = 0; mFa = 0; mIrq = 0; mPf = 0;
    for (int p = 0; p < 4; p++) begin
      reqV[p] = 0; rAddr[p] = '0; rTag[p] = '0; rCtrl[p] = '0; lastAcc[p] = 0;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rstN) begin
      // R10 reset state
      chk(outValid == 0 && rundown == 0 && missIrq == 0 && pfMissRpt == 0,
          "R10", "reset flags", {outValid, rundown, missIrq, pfMissRpt}, 0);
      chk(failAddr == 0, "R10", "reset failAddr", failAddr, 0);
      chk({hpAcc, oaAcc, obAcc, pfAcc, dropFlag} == 0, "R10", "reset accepts",
          {hpAcc, oaAcc, obAcc, pfAcc, dropFlag}, 0);
      for (int i = 0; i < 3; i++) nV[i] = 0;
      nRd = 0; nFa = 0; nIrq = 0; nPf = 0;
      for (int p = 0; p < 4; p++) lastAcc[p] = 0;
    end else begin
      int win, ret, advB, advA, aFree, isRes, disc, take, trig, pfTrig;
      bit expAcc [4];
      win = -1;
      for (int p = 3; p >= 0; p--) if (reqV[p]) win = p;
      ret   = mV[2] && outReady;
      advB  = mV[1] && (!mV[2] || ret);
      advA  = mV[0] && (!mV[1] || advB);
      aFree = !mV[0] || advA;
      isRes = (win == 2) && obRes;
      disc  = (win >= 0) && mRd && !isRes;
      take  = (win >= 0) && !disc && aFree;
      trig  = ret && outMiss && !mRd && (mS[2] != 3);
      pfTrig = ret && outMiss && (mS[2] == 3);
      for (int p = 0; p < 4; p++) expAcc[p] = (disc || take) && (win == p);

      if (!aFree && !mRd)
        chk({hpAcc, oaAcc, obAcc, pfAcc} == {expAcc[0], expAcc[1], expAcc[2], expAcc[3]},
            "R3", "accepts while stage A held", {hpAcc, oaAcc, obAcc, pfAcc},
            {expAcc[0], expAcc[1], expAcc[2], expAcc[3]});
      else
        chk({hpAcc, oaAcc, obAcc, pfAcc} == {expAcc[0], expAcc[1], expAcc[2], expAcc[3]},
            "R1", "accept vector", {hpAcc, oaAcc, obAcc, pfAcc},
            {expAcc[0], expAcc[1], expAcc[2], expAcc[3]});
      chk(dropFlag == disc, "R7", "dropFlag", dropFlag, disc);
      chk(outValid == mV[2], mRd ? "R8" : "R2", "outValid", outValid, mV[2]);
      if (mV[2])
        chk(outAddr == mA[2] && outTag == mT[2] && outCtrl == mC[2] && outSrc == mS[2],
            mRd ? "R8" : "R2", "output entry addr", outAddr, mA[2]);
      chk(failAddr == mFa, mRd ? "R6" : "R4", "failAddr", failAddr, mFa);
      chk(missIrq == mIrq, "R5", "missIrq", missIrq, mIrq);
      chk(pfMissRpt == mPf, "R5", "pfMissRpt", pfMissRpt, mPf);
      chk(rundown == mRd, "R9", "rundown", rundown, mRd);

      for (int i = 0; i < 3; i++) begin
        nV[i] = mV[i]; nA[i] = mA[i]; nT[i] = mT[i]; nC[i] = mC[i]; nS[i] = mS[i];
      end
      nIrq = trig; nPf = pfTrig; nRd = mRd; nFa = mFa;
      if (trig) nRd = 1;
      else if (take && isRes) nRd = 0;
      if (advB && !mRd && !trig) nFa = mA[1];
      if (advB) begin
        nV[2] = 1; nA[2] = mA[1]; nT[2] = mT[1]; nC[2] = mC[1]; nS[2] = mS[1];
      end else if (ret) nV[2] = 0;
      if (advA) begin
        nV[1] = 1; nA[1] = mA[0]; nT[1] = mT[0]; nC[1] = mC[0]; nS[1] = mS[0];
      end else if (advB) nV[1] = 0;
      if (take) begin
        nV[0] = 1; nA[0] = rAddr[win]; nT[0] = rTag[win]; nC[0] = rCtrl[win]; nS[0] = win;
      end else if (advA) nV[0] = 0;
      for (int p = 0; p < 4; p++) lastAcc[p] = expAcc[p];
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      mV[i] = nV[i]; mA[i] = nA[i]; mT[i] = nT[i]; mC[i] = nC[i]; mS[i] = nS[i];
    end
    mRd = nRd; mFa = nFa; mIrq = nIrq; mPf = nPf;
  end

  task automatic drive();
    for (int p = 0; p < 4; p++) begin
      if (!reqV[p] || lastAcc[p]) begin
        reqV[p]  = ($urandom % 100) < reqPct;
        rAddr[p] = AW'($urandom);
        rTag[p]  = TW'($urandom);
        rCtrl[p] = CW'($urandom);
        if (p == 2) obRes = ($urandom % 100) < resPct;
      end
    end
    outReady = ($urandom % 100) < readyPct;
    outMiss  = ($urandom % 100) < missPct;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      drive();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    reqPct = 70; readyPct = 100; missPct = 0;  run(600);   // R1 R2 dense flow
    reqPct = 60; readyPct = 30;  missPct = 0;  run(800);   // R3 stalls
    reqPct = 50; readyPct = 70;  missPct = 8;  resPct = 15; run(2500); // R5..R9
    reqPct = 90; readyPct = 50;  missPct = 20; resPct = 5;  run(2500);
    reqPct = 20; readyPct = 90;  missPct = 3;  resPct = 40; run(1500);
    for (int p = 0; p < 4; p++) reqV[p] = 0;
    reqPct = 0; missPct = 0; resPct = 100; run(20);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule